// File: doc/BRIEF.md
# DMA Host Register Interface

This block is the processor-facing side of a four-channel DMA controller that sits on an 8-bit I/O bus. It stores a 16-bit base address, current address, base word count and current word count for every channel. Because the host bus is one byte wide, each 16-bit value is reached in two accesses. A byte pointer flip-flop picks the low or high half and flips after every such access. The host can force the pointer to either state with data-independent commands.

The same decoder recognises several software commands by their address and strobe direction alone. These commands clear or set the byte pointer, perform a master clear, clear the channel mask and reset the mode read-back counter. Mode registers are written with the channel number in the data byte. They are read back in order through a two-bit counter that advances on each read. Every access takes effect once, when the clock detects the rising edge of the read or write strobe while chip select is active.

The transfer engine, channel priority and bus timing are outside this block. It hands the engine the base values, the mask bits and a one-cycle master-clear pulse.

Top module: `dma_host_regs`

## Requirements
- R1: With addr[3]=0, addr[2:1] selects channel 0..3, and addr[0]=0 selects the address register while addr[0]=1 selects the word count register.
- R2: A write to an address or word count register loads both the base and the current copy, and the base copy appears on base_addr_o / base_cnt_o (channel n at bits 16n+15:16n). A read returns the current copy.
- R3: When the byte pointer is 0 an address/count access uses bits 7:0, and when it is 1 the access uses bits 15:8. The pointer toggles after every address/count read or write.
- R4: A write to addr 4'b1100 forces the pointer to 0 and a write to 4'b1111 forces it to 1, whatever the data byte.
- R5: A write to addr 4'b1011 stores din[7:2] as the mode of the channel given by din[1:0]. A read of 4'b1011 returns {mode, 2'b11} for the channel named by the mode counter, then advances the counter 0,1,2,3,0.
- R6: A read of addr 4'b1110 resets the mode counter to channel 0.
- R7: A write to addr 4'b1101 (master clear) forces the pointer to 0, the mode counter to 0 and all four mask bits to 1, and raises mclr_o for exactly one cycle.
- R8: A write to addr 4'b1110 clears all four mask bits.
- R9: An access acts once, on the rising edge of ior_n or iow_n seen while cs_n is low. A strobe with cs_n high, or a strobe held low for many cycles, has no further effect.
- R10: After reset the mask bits are 1111, the pointer, mode counter and all registers are 0, and dout is 0 whenever cs_n or ior_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| ior_n | input | 1 | Active-low read strobe |
| iow_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Register / command select |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte, zero when not reading |
| base_addr_o | output | 64 | Base address of each channel, packed |
| base_cnt_o | output | 64 | Base word count of each channel, packed |
| mask_o | output | 4 | Channel mask bits, 1 = masked |
| mclr_o | output | 1 | One-cycle pulse after a master clear |

## Verification
The assertions watch on every cycle the properties that reduce to a relation between a strobe and the next state. These are the idle-bus zero on dout, the forced ones in mode read-back, the pointer flipping on each register access and holding while deselected, the mask after clear or master clear, and the single-cycle master-clear pulse. Only the bench scenarios can show which byte lands where across a two-access sequence, and that channel and register decode is correct across all four channels. The bench scenarios also cover the order and wrap of the mode read-back counter, and that a held strobe acts only once.

// File: rtl/dma_host_pkg.sv
package dma_host_pkg;

    localparam logic [3:0] CODE_MODE     = 4'b1011;
    localparam logic [3:0] CODE_CLR_PTR  = 4'b1100;
    localparam logic [3:0] CODE_MCLR     = 4'b1101;
    localparam logic [3:0] CODE_CLR_MASK = 4'b1110;
    localparam logic [3:0] CODE_CLR_MCNT = 4'b1110;
    localparam logic [3:0] CODE_SET_PTR  = 4'b1111;

    typedef struct packed {
        logic wr_reg;
        logic rd_reg;
        logic clr_ptr;
        logic set_ptr;
        logic mclr;
        logic clr_mask;
        logic clr_mcnt;
        logic wr_mode;
        logic rd_mode;
    } dma_cmd_t;

endpackage

// File: rtl/dma_io_strobe.sv
module dma_io_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ior_n,
    input  logic iow_n,
    output logic rd_stb,
    output logic wr_stb
);
    typedef struct packed {
        logic ior;
        logic iow;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d.ior = ior_n;
        st_d.iow = iow_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ior: 1'b1, iow: 1'b1};
        else        st_q <= st_d;
    end

    // rising edge of a strobe while selected
    assign rd_stb = !cs_n && !st_q.ior && ior_n;
    assign wr_stb = !cs_n && !st_q.iow && iow_n;
endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_host_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       rd_stb,
    input  logic       wr_stb,
    output dma_cmd_t   cmd
);
    always_comb begin
        cmd          = '0;
        cmd.wr_reg   = wr_stb && !addr[3];
        cmd.rd_reg   = rd_stb && !addr[3];
        cmd.clr_ptr  = wr_stb && (addr == CODE_CLR_PTR);
        cmd.set_ptr  = wr_stb && (addr == CODE_SET_PTR);
        cmd.mclr     = wr_stb && (addr == CODE_MCLR);
        cmd.clr_mask = wr_stb && (addr == CODE_CLR_MASK);
        cmd.clr_mcnt = rd_stb && (addr == CODE_CLR_MCNT);
        cmd.wr_mode  = wr_stb && (addr == CODE_MODE);
        cmd.rd_mode  = rd_stb && (addr == CODE_MODE);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int unsigned DW = 8,
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_sel,
    input  logic [DW-1:0] din,
    output logic [RW-1:0] base_addr,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] base_cnt,
    output logic [RW-1:0] cur_cnt
);
    localparam int unsigned HW = RW - DW;

    typedef struct packed {
        logic [RW-1:0] base_addr;
        logic [RW-1:0] cur_addr;
        logic [RW-1:0] base_cnt;
        logic [RW-1:0] cur_cnt;
    } chan_t;

    chan_t ch_d, ch_q;

    function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] w,
                                               input logic hi,
                                               input logic [DW-1:0] b);
        logic [RW-1:0] r;
        r = w;
        if (hi) r[RW-1:DW] = b[HW-1:0];
        else    r[DW-1:0]  = b;
        return r;
    endfunction

    always_comb begin
        ch_d = ch_q;
        if (wr_addr) begin
            ch_d.base_addr = put_byte(ch_q.base_addr, hi_sel, din);
            ch_d.cur_addr  = put_byte(ch_q.cur_addr,  hi_sel, din);
        end
        if (wr_cnt) begin
            ch_d.base_cnt = put_byte(ch_q.base_cnt, hi_sel, din);
            ch_d.cur_cnt  = put_byte(ch_q.cur_cnt,  hi_sel, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign base_addr = ch_q.base_addr;
    assign cur_addr  = ch_q.cur_addr;
    assign base_cnt  = ch_q.base_cnt;
    assign cur_cnt   = ch_q.cur_cnt;
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
    import dma_host_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DW     = 8,
    parameter int unsigned RW     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic [3:0]         addr,
    input  logic [DW-1:0]      din,
    output logic [DW-1:0]      dout,
    output logic [NUM_CH*RW-1:0] base_addr_o,
    output logic [NUM_CH*RW-1:0] base_cnt_o,
    output logic [NUM_CH-1:0]  mask_o,
    output logic               mclr_o
);
    localparam int unsigned CHW = $clog2(NUM_CH);
    localparam int unsigned MW  = DW - 2;

    typedef struct packed {
        logic                       ptr;
        logic [CHW-1:0]             mcnt;
        logic [NUM_CH-1:0]          mask;
        logic                       mclr;
        logic [NUM_CH-1:0][MW-1:0]  mode;
    } top_t;

    top_t     q, d;
    logic     rd_stb, wr_stb;
    dma_cmd_t cmd;
    logic     ptr_cur;

    logic [RW-1:0] cur_addr_w [NUM_CH];
    logic [RW-1:0] cur_cnt_w  [NUM_CH];
    logic [CHW-1:0] ch_sel;

    assign ch_sel  = addr[CHW:1];
    assign ptr_cur = q.ptr;

    dma_io_strobe u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .ior_n  (ior_n),
        .iow_n  (iow_n),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb)
    );

    dma_cmd_decode u_dec (
        .addr   (addr),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .cmd    (cmd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = (ch_sel == CHW'(i));

        dma_chan_regs #(.DW(DW), .RW(RW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (cmd.wr_reg && sel && !addr[0]),
            .wr_cnt    (cmd.wr_reg && sel &&  addr[0]),
            .hi_sel    (q.ptr),
            .din       (din),
            .base_addr (base_addr_o[i*RW +: RW]),
            .cur_addr  (cur_addr_w[i]),
            .base_cnt  (base_cnt_o[i*RW +: RW]),
            .cur_cnt   (cur_cnt_w[i])
        );
    end

    always_comb begin
        d      = q;
        d.mclr = 1'b0;
        if (cmd.wr_reg || cmd.rd_reg) d.ptr = !q.ptr;
        if (cmd.clr_ptr)              d.ptr = 1'b0;
        if (cmd.set_ptr)              d.ptr = 1'b1;
        if (cmd.rd_mode)              d.mcnt = q.mcnt + 1'b1;
        if (cmd.clr_mcnt)             d.mcnt = '0;
        if (cmd.wr_mode)              d.mode[din[CHW-1:0]] = din[DW-1:2];
        if (cmd.clr_mask)             d.mask = '0;
        if (cmd.mclr) begin
            d.ptr  = 1'b0;
            d.mcnt = '0;
            d.mask = '1;
            d.mclr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        logic [RW-1:0] word;
        word = addr[0] ? cur_cnt_w[ch_sel] : cur_addr_w[ch_sel];
        dout = '0;
        if (!cs_n && !ior_n) begin
            if (!addr[3])
                dout = q.ptr ? DW'(word >> DW) : word[DW-1:0];
            else if (addr == CODE_MODE)
                dout = {q.mode[q.mcnt], 2'b11};
        end
    end

    assign mask_o = q.mask;
    assign mclr_o = q.mclr;
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ior_n,
    input logic              iow_n,
    input logic [3:0]        addr,
    input logic [DW-1:0]     dout,
    input logic [NUM_CH-1:0] mask_o,
    input logic              mclr_o,
    input logic              ptr
);
    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || ior_n) |-> (dout == '0));

    assert_mode_low_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ior_n && addr == 4'b1011) |-> (dout[1:0] == 2'b11));

    assert_ptr_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !addr[3] && ((iow_n && !$past(iow_n)) || (ior_n && !$past(ior_n))))
        |=> (ptr != $past(ptr)));

    assert_ptr_hold_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(ptr));

    assert_mclr_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_o |-> (mask_o == '1));

    assert_mclr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_o |=> !mclr_o);

    assert_clr_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && iow_n && !$past(iow_n) && addr == 4'b1110) |=> (mask_o == '0));
endmodule

bind dma_host_regs dma_host_regs_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .ior_n  (ior_n),
    .iow_n  (iow_n),
    .addr   (addr),
    .dout   (dout),
    .mask_o (mask_o),
    .mclr_o (mclr_o),
    .ptr    (ptr_cur)
);

// File: tb/tb_dma_host_regs.sv
`timescale 1ns/1ps
module tb_dma_host_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ior_n, iow_n;
    logic [3:0]  addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic [63:0] base_addr_o, base_cnt_o;
    logic [3:0]  mask_o;
    logic        mclr_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_host_regs dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ior_n(ior_n), .iow_n(iow_n),
        .addr(addr), .din(din), .dout(dout), .base_addr_o(base_addr_o),
        .base_cnt_o(base_cnt_o), .mask_o(mask_o), .mclr_o(mclr_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; addr = a; din = v; iow_n = 1'b0;
        @(negedge clk); iow_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; addr = a; ior_n = 1'b0;
        @(negedge clk); v = dout; ior_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic wr16(input int ch, input logic cnt, input logic [15:0] v);
        io_write(4'b1100, 8'h00);
        io_write({1'b0, 2'(ch), cnt}, v[7:0]);
        io_write({1'b0, 2'(ch), cnt}, v[15:8]);
    endtask

    task automatic rd16(input int ch, input logic cnt, output logic [15:0] v);
        logic [7:0] lo, hi;
        io_write(4'b1100, 8'h00);
        io_read({1'b0, 2'(ch), cnt}, lo);
        io_read({1'b0, 2'(ch), cnt}, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R10 mask after reset", mask_o, 4'hF);
        chk("R10 mclr idle", mclr_o, 1'b0);
        chk("R10 dout idle", dout, 8'h00);
        chk("R10 base addr zero", base_addr_o, 64'h0);
        io_read(4'b0000, v);
        chk("R10 ch0 addr low zero", v, 8'h00);
    endtask

    task automatic t_decode();
        logic [15:0] v;
        for (int ch = 0; ch < 4; ch++) begin
            wr16(ch, 1'b0, 16'h1200 + 16'(ch * 16'h0111));
            wr16(ch, 1'b1, 16'hA005 + 16'(ch * 16'h0230));
        end
        for (int ch = 0; ch < 4; ch++) begin
            rd16(ch, 1'b0, v);
            chk("R1 R2 address readback", v, 16'h1200 + 16'(ch * 16'h0111));
            rd16(ch, 1'b1, v);
            chk("R1 R2 count readback", v, 16'hA005 + 16'(ch * 16'h0230));
            chk("R2 base address port", base_addr_o[ch*16 +: 16], 16'h1200 + 16'(ch * 16'h0111));
            chk("R2 base count port", base_cnt_o[ch*16 +: 16], 16'hA005 + 16'(ch * 16'h0230));
        end
    endtask

    task automatic t_ptr();
        logic [7:0] v;
        wr16(3, 1'b0, 16'h1122);
        io_write(4'b1111, 8'h00);
        io_write(4'b0110, 8'hAB);
        io_write(4'b1100, 8'hFF);
        io_read(4'b0110, v);
        chk("R3 R4 low byte after clear", v, 8'h22);
        io_read(4'b0110, v);
        chk("R3 R4 high byte written after set", v, 8'hAB);
        io_read(4'b0110, v);
        chk("R3 pointer wraps to low", v, 8'h22);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        io_write(4'b1011, 8'hA4);
        io_write(4'b1011, 8'h51);
        io_write(4'b1011, 8'hFE);
        io_write(4'b1011, 8'h03);
        io_read(4'b1110, v);
        io_read(4'b1011, v); chk("R5 mode ch0", v, 8'hA7);
        io_read(4'b1011, v); chk("R5 mode ch1", v, 8'h53);
        io_read(4'b1011, v); chk("R5 mode ch2", v, 8'hFF);
        io_read(4'b1011, v); chk("R5 mode ch3", v, 8'h03);
        io_read(4'b1011, v); chk("R5 mode counter wraps", v, 8'hA7);
        io_read(4'b1011, v);
        io_read(4'b1110, v);
        io_read(4'b1011, v); chk("R6 counter cleared", v, 8'hA7);
    endtask

    task automatic t_mask_mclr();
        logic [7:0] v;
        io_write(4'b1110, 8'h5A);
        chk("R8 mask cleared", mask_o, 4'h0);
        io_write(4'b1111, 8'h00);
        io_read(4'b1011, v);
        io_read(4'b1011, v);
        io_write(4'b1101, 8'hA5);
        chk("R7 mclr pulse high", mclr_o, 1'b1);
        chk("R7 mask set", mask_o, 4'hF);
        @(negedge clk);
        chk("R7 mclr pulse one cycle", mclr_o, 1'b0);
        io_read(4'b0110, v);
        chk("R7 pointer low after mclr", v, 8'h22);
        io_read(4'b1011, v);
        chk("R7 mode counter zero after mclr", v, 8'hA7);
    endtask

    task automatic t_once();
        logic [7:0] v;
        io_write(4'b1100, 8'h00);
        @(negedge clk); cs_n = 1'b1; addr = 4'b0010; din = 8'h77; iow_n = 1'b0;
        @(negedge clk); iow_n = 1'b1;
        @(negedge clk);
        io_read(4'b0010, v);
        chk("R9 deselected write ignored", v, 8'h11);
        io_write(4'b1100, 8'h00);
        @(negedge clk); cs_n = 1'b0; addr = 4'b0010; din = 8'h5A; iow_n = 1'b0;
        repeat (5) @(negedge clk);
        iow_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        io_read(4'b0010, v);
        chk("R9 held strobe toggles once", v, 8'h13);
        io_read(4'b0010, v);
        chk("R9 held strobe wrote low byte", v, 8'h5A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1; addr = '0; din = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_ptr();
        t_mode();
        t_mask_mclr();
        t_once();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule